// File: doc/BRIEF.md
# DRAM Bank Timing Tracker

This block keeps the per-bank timing state of one DRAM rank for a memory controller. It runs in controller clock cycles. It watches four command strobes: activate, precharge, read and write, each with its own bank index. For every bank it reports which commands are legal in the current cycle. Read and write column commands each have their own activate-to-column delay and their own column-to-data latency. Every rule derived from these values uses the one that matches the command direction.

Each bank is a two-state machine. CLOSED moves to OPEN on an ACTIVATE, and OPEN moves back to CLOSED on a PRECHARGE. Each bank also stores the earliest cycle at which each command becomes legal. A second machine holds the protocol status: CLEAN moves to FAULTED on the first illegal strobe and then stays in FAULTED until reset.

Eight 8-bit timing values can be programmed, but only while every bank is closed. The block reports several values:
- the data-completion cycle of each accepted read or write burst;
- the unloaded closed-bank access latency;
- the worst-case command offset;
- the latest activate cycle that still stays hidden behind a planned column command.

A scheduler drives the strobes only when the matching flag is high. The error bit catches any strobe that breaks this rule.

Top module: `bank_timer`

## Requirements
- R1: After reset every bank is CLOSED, `act_ok` is all ones, `pre_ok`, `rd_ok` and `wr_ok` are all zero, `proto_err` and `done_valid` are low, and `now` counts up by one per cycle starting at 0.
- R2: After an accepted activate at cycle A, `rd_ok` for that bank is low before cycle A+rcd_rd and high from A+rcd_rd on. That allowed cycle never moves earlier than a previously recorded read limit.
- R3: After an accepted activate at cycle A, `wr_ok` for that bank rises at A+rcd_wr. Until rcd_wr is programmed, it takes the value of rcd_rd.
- R4: A precharge is legal only on an OPEN bank, from A+ras on. An activate is legal only on a CLOSED bank, from P+rp after its precharge at cycle P. Read and write are legal only on an OPEN bank.
- R5: For a read accepted at cycle C, `done_valid` is high in cycle C+1 with `done_at` = C + cl_rd + burst.
- R6: For a write accepted at cycle C, `done_valid` is high in cycle C+1 with `done_at` = C + cl_wr + burst. Until cl_wr is programmed, it takes the value of cl_rd.
- R7: After a write accepted at cycle W, no read to any bank is legal before W + burst + wtr + cl_wr.
- R8: `access_lat` always equals rp + rcd_rd + cl_rd.
- R9: `cmd_offset` always equals rp + max(rcd_rd, effective rcd_wr).
- R10: `hidden_act_at` equals `col_at` minus rcd_wr when `bus_wr_mode` is 1, or minus rcd_rd when it is 0. The result is clamped to no earlier than `now`.
- R11: Each of the following sets `proto_err` from the next cycle until reset, and changes no bank state: a strobe whose flag is low, or more than one strobe in the same cycle.
- R12: A timing write (`cfg_we`) is accepted only when every bank is CLOSED and is ignored otherwise. The `cfg_sel` codes are 0 rcd_rd, 1 rcd_wr, 2 cl_rd, 3 cl_wr, 4 ras, 5 rp, 6 burst, 7 wtr. The reset values are rcd_rd 4, cl_rd 5, ras 8, rp 3, burst 2 and wtr 2; rcd_wr and cl_wr start unprogrammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_sel | input | 3 | Timing register selector |
| cfg_data | input | 8 | Timing value in cycles |
| act_req | input | 1 | Activate strobe |
| act_bank | input | 2 | Activate bank index |
| pre_req | input | 1 | Precharge strobe |
| pre_bank | input | 2 | Precharge bank index |
| rd_req | input | 1 | Read strobe |
| rd_bank | input | 2 | Read bank index |
| wr_req | input | 1 | Write strobe |
| wr_bank | input | 2 | Write bank index |
| bus_wr_mode | input | 1 | Data bus direction for the hidden-activate query (1 = write) |
| col_at | input | 24 | Planned column command cycle for the hidden-activate query |
| act_ok | output | 4 | Per-bank activate legal |
| pre_ok | output | 4 | Per-bank precharge legal |
| rd_ok | output | 4 | Per-bank read legal |
| wr_ok | output | 4 | Per-bank write legal |
| done_valid | output | 1 | A burst completion cycle is being reported |
| done_at | output | 24 | Cycle at which that burst's data completes |
| now | output | 24 | Current cycle count |
| access_lat | output | 10 | Unloaded closed-bank access latency |
| cmd_offset | output | 9 | Worst-case command offset |
| hidden_act_at | output | 24 | Latest activate cycle hidden behind `col_at` |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The legality flags are checked in every cycle around each edge, not only at one cycle. This shows an off-by-one in a delay as well as a read/write swap.

The timing values are exercised in two configurations:
- With write delays unprogrammed, the write values must follow the read values.
- With distinct write delays, the read delay and the write delay must give different answers.

A write followed by a read checks that the turnaround uses the write latency. The hidden-activate query is tried in both bus directions, with a target far ahead and with a target at or inside the delay, which exercises the clamp. Illegal single strobes and simultaneous strobes must raise the error and leave the bank state visibly untouched.

// File: rtl/bank_timer_pkg.sv
package bank_timer_pkg;

    typedef enum logic {
        BK_CLOSED = 1'b0,
        BK_OPEN   = 1'b1
    } bank_state_e;

    typedef enum logic {
        ST_CLEAN   = 1'b0,
        ST_FAULTED = 1'b1
    } err_state_e;

    typedef enum logic [2:0] {
        SEL_RCD_RD = 3'd0,
        SEL_RCD_WR = 3'd1,
        SEL_CL_RD  = 3'd2,
        SEL_CL_WR  = 3'd3,
        SEL_RAS    = 3'd4,
        SEL_RP     = 3'd5,
        SEL_BURST  = 3'd6,
        SEL_WTR    = 3'd7
    } cfg_sel_e;

    localparam int unsigned RST_RCD   = 4;
    localparam int unsigned RST_CL    = 5;
    localparam int unsigned RST_RAS   = 8;
    localparam int unsigned RST_RP    = 3;
    localparam int unsigned RST_BURST = 2;
    localparam int unsigned RST_WTR   = 2;

endpackage

// File: rtl/bt_timing_regs.sv
module bt_timing_regs
    import bank_timer_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [TW-1:0] cfg_data,
    input  logic          all_closed,
    output logic [TW-1:0] rcd_rd,
    output logic [TW-1:0] rcd_wr,
    output logic [TW-1:0] cl_rd,
    output logic [TW-1:0] cl_wr,
    output logic [TW-1:0] ras,
    output logic [TW-1:0] rp,
    output logic [TW-1:0] burst,
    output logic [TW-1:0] wtr,
    output logic [TW+1:0] access_lat,
    output logic [TW:0]   cmd_offset
);

    logic [TW-1:0] r_rcd_rd, r_rcd_wr, r_cl_rd, r_cl_wr;
    logic [TW-1:0] r_ras, r_rp, r_burst, r_wtr;
    logic          rcd_wr_set, cl_wr_set;
    logic          wr_take;

    assign wr_take = cfg_we && all_closed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_rcd_rd   <= TW'(RST_RCD);
            r_rcd_wr   <= TW'(RST_RCD);
            r_cl_rd    <= TW'(RST_CL);
            r_cl_wr    <= TW'(RST_CL);
            r_ras      <= TW'(RST_RAS);
            r_rp       <= TW'(RST_RP);
            r_burst    <= TW'(RST_BURST);
            r_wtr      <= TW'(RST_WTR);
            rcd_wr_set <= 1'b0;
            cl_wr_set  <= 1'b0;
        end else if (wr_take) begin
            unique case (cfg_sel_e'(cfg_sel))
                SEL_RCD_RD: r_rcd_rd <= cfg_data;
                SEL_RCD_WR: begin
                    r_rcd_wr   <= cfg_data;
                    rcd_wr_set <= 1'b1;
                end
                SEL_CL_RD:  r_cl_rd <= cfg_data;
                SEL_CL_WR: begin
                    r_cl_wr   <= cfg_data;
                    cl_wr_set <= 1'b1;
                end
                SEL_RAS:    r_ras   <= cfg_data;
                SEL_RP:     r_rp    <= cfg_data;
                SEL_BURST:  r_burst <= cfg_data;
                SEL_WTR:    r_wtr   <= cfg_data;
            endcase
        end
    end

    // Unprogrammed write timings follow their read counterparts
    assign rcd_rd = r_rcd_rd;
    assign rcd_wr = rcd_wr_set ? r_rcd_wr : r_rcd_rd;
    assign cl_rd  = r_cl_rd;
    assign cl_wr  = cl_wr_set ? r_cl_wr : r_cl_rd;
    assign ras    = r_ras;
    assign rp     = r_rp;
    assign burst  = r_burst;
    assign wtr    = r_wtr;

    always_comb begin
        access_lat = (TW+2)'(r_rp) + (TW+2)'(r_rcd_rd) + (TW+2)'(r_cl_rd);
        if (rcd_wr > r_rcd_rd)
            cmd_offset = (TW+1)'(r_rp) + (TW+1)'(rcd_wr);
        else
            cmd_offset = (TW+1)'(r_rp) + (TW+1)'(r_rcd_rd);
    end

endmodule

// File: rtl/bt_bank_fsm.sv
module bt_bank_fsm
    import bank_timer_pkg::*;
#(
    parameter int TW = 8,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] now,
    input  logic          do_act,
    input  logic          do_pre,
    input  logic [TW-1:0] rcd_rd,
    input  logic [TW-1:0] rcd_wr,
    input  logic [TW-1:0] ras,
    input  logic [TW-1:0] rp,
    output logic          act_ok,
    output logic          pre_ok,
    output logic          rd_ok,
    output logic          wr_ok,
    output logic          is_closed
);

    bank_state_e   state, state_nx;
    logic [CW-1:0] rd_at, wr_at, pre_at, act_at;
    logic [CW-1:0] rd_nx, wr_nx, pre_nx, act_nx;
    logic [CW-1:0] rd_cand, wr_cand;

    assign rd_cand = now + CW'(rcd_rd);
    assign wr_cand = now + CW'(rcd_wr);

    // Next state and timestamps
    always_comb begin
        state_nx = state;
        rd_nx    = rd_at;
        wr_nx    = wr_at;
        pre_nx   = pre_at;
        act_nx   = act_at;
        unique case (state)
            BK_CLOSED: begin
                if (do_act) begin
                    state_nx = BK_OPEN;
                    rd_nx    = (rd_cand > rd_at) ? rd_cand : rd_at;
                    wr_nx    = (wr_cand > wr_at) ? wr_cand : wr_at;
                    pre_nx   = now + CW'(ras);
                end
            end
            BK_OPEN: begin
                if (do_pre) begin
                    state_nx = BK_CLOSED;
                    act_nx   = now + CW'(rp);
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= BK_CLOSED;
            rd_at  <= '0;
            wr_at  <= '0;
            pre_at <= '0;
            act_at <= '0;
        end else begin
            state  <= state_nx;
            rd_at  <= rd_nx;
            wr_at  <= wr_nx;
            pre_at <= pre_nx;
            act_at <= act_nx;
        end
    end

    // Outputs
    always_comb begin
        act_ok    = 1'b0;
        pre_ok    = 1'b0;
        rd_ok     = 1'b0;
        wr_ok     = 1'b0;
        is_closed = 1'b0;
        unique case (state)
            BK_CLOSED: begin
                is_closed = 1'b1;
                act_ok    = (now >= act_at);
            end
            BK_OPEN: begin
                pre_ok = (now >= pre_at);
                rd_ok  = (now >= rd_at);
                wr_ok  = (now >= wr_at);
            end
        endcase
    end

endmodule

// File: rtl/bt_issue.sv
module bt_issue
    import bank_timer_pkg::*;
#(
    parameter int NB = 4,
    parameter int TW = 8,
    parameter int CW = 24,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_req,
    input  logic [BW-1:0] act_bank,
    input  logic          pre_req,
    input  logic [BW-1:0] pre_bank,
    input  logic          rd_req,
    input  logic [BW-1:0] rd_bank,
    input  logic          wr_req,
    input  logic [BW-1:0] wr_bank,
    input  logic [NB-1:0] act_ok,
    input  logic [NB-1:0] pre_ok,
    input  logic [NB-1:0] rd_ok,
    input  logic [NB-1:0] wr_ok,
    input  logic [CW-1:0] now,
    input  logic [TW-1:0] cl_rd,
    input  logic [TW-1:0] cl_wr,
    input  logic [TW-1:0] burst,
    input  logic [TW-1:0] wtr,
    output logic [NB-1:0] act_go,
    output logic [NB-1:0] pre_go,
    output logic          rd_gate_ok,
    output logic          done_valid,
    output logic [CW-1:0] done_at,
    output logic          proto_err
);

    err_state_e    est, est_nx;
    logic [2:0]    n_req;
    logic          any_req, legal, accept, rd_acc, wr_acc;
    logic [CW-1:0] rd_gate;

    always_comb begin
        n_req   = 3'(act_req) + 3'(pre_req) + 3'(rd_req) + 3'(wr_req);
        any_req = (n_req != 3'd0);
        legal   = (act_req && act_ok[act_bank]) || (pre_req && pre_ok[pre_bank]) ||
                  (rd_req && rd_ok[rd_bank]) || (wr_req && wr_ok[wr_bank]);
        accept  = (n_req == 3'd1) && legal;
        rd_acc  = accept && rd_req;
        wr_acc  = accept && wr_req;
        for (int b = 0; b < NB; b++) begin
            act_go[b] = accept && act_req && (act_bank == BW'(b));
            pre_go[b] = accept && pre_req && (pre_bank == BW'(b));
        end
    end

    // Error state machine: next state
    always_comb begin
        est_nx = est;
        unique case (est)
            ST_CLEAN:   if (any_req && !accept) est_nx = ST_FAULTED;
            ST_FAULTED: est_nx = ST_FAULTED;
        endcase
    end

    // State register and burst bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            est        <= ST_CLEAN;
            rd_gate    <= '0;
            done_valid <= 1'b0;
            done_at    <= '0;
        end else begin
            est        <= est_nx;
            done_valid <= rd_acc || wr_acc;
            if (rd_acc)
                done_at <= now + CW'(cl_rd) + CW'(burst);
            else if (wr_acc)
                done_at <= now + CW'(cl_wr) + CW'(burst);
            if (wr_acc)
                rd_gate <= now + CW'(burst) + CW'(wtr) + CW'(cl_wr);
        end
    end

    // Outputs
    always_comb begin
        rd_gate_ok = (now >= rd_gate);
        unique case (est)
            ST_CLEAN:   proto_err = 1'b0;
            ST_FAULTED: proto_err = 1'b1;
        endcase
    end

endmodule

// File: rtl/bank_timer.sv
module bank_timer
    import bank_timer_pkg::*;
#(
    parameter int NB = 4,
    parameter int TW = 8,
    parameter int CW = 24,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [TW-1:0] cfg_data,
    input  logic          act_req,
    input  logic [BW-1:0] act_bank,
    input  logic          pre_req,
    input  logic [BW-1:0] pre_bank,
    input  logic          rd_req,
    input  logic [BW-1:0] rd_bank,
    input  logic          wr_req,
    input  logic [BW-1:0] wr_bank,
    input  logic          bus_wr_mode,
    input  logic [CW-1:0] col_at,
    output logic [NB-1:0] act_ok,
    output logic [NB-1:0] pre_ok,
    output logic [NB-1:0] rd_ok,
    output logic [NB-1:0] wr_ok,
    output logic          done_valid,
    output logic [CW-1:0] done_at,
    output logic [CW-1:0] now,
    output logic [TW+1:0] access_lat,
    output logic [TW:0]   cmd_offset,
    output logic [CW-1:0] hidden_act_at,
    output logic          proto_err
);

    logic [TW-1:0] rcd_rd, rcd_wr, cl_rd, cl_wr, ras, rp, burst, wtr;
    logic [NB-1:0] bank_rd_ok, closed, act_go, pre_go;
    logic          rd_gate_ok;
    logic [CW-1:0] cyc;
    logic [TW-1:0] rcd_dir;
    logic [CW:0]   hide_floor;

    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 1'b1;
    end
    assign now = cyc;

    bt_timing_regs #(.TW(TW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_data   (cfg_data),
        .all_closed (&closed),
        .rcd_rd     (rcd_rd),
        .rcd_wr     (rcd_wr),
        .cl_rd      (cl_rd),
        .cl_wr      (cl_wr),
        .ras        (ras),
        .rp         (rp),
        .burst      (burst),
        .wtr        (wtr),
        .access_lat (access_lat),
        .cmd_offset (cmd_offset)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        bt_bank_fsm #(.TW(TW), .CW(CW)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .now       (cyc),
            .do_act    (act_go[b]),
            .do_pre    (pre_go[b]),
            .rcd_rd    (rcd_rd),
            .rcd_wr    (rcd_wr),
            .ras       (ras),
            .rp        (rp),
            .act_ok    (act_ok[b]),
            .pre_ok    (pre_ok[b]),
            .rd_ok     (bank_rd_ok[b]),
            .wr_ok     (wr_ok[b]),
            .is_closed (closed[b])
        );
        assign rd_ok[b] = bank_rd_ok[b] && rd_gate_ok;
    end

    bt_issue #(.NB(NB), .TW(TW), .CW(CW)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_req    (act_req),
        .act_bank   (act_bank),
        .pre_req    (pre_req),
        .pre_bank   (pre_bank),
        .rd_req     (rd_req),
        .rd_bank    (rd_bank),
        .wr_req     (wr_req),
        .wr_bank    (wr_bank),
        .act_ok     (act_ok),
        .pre_ok     (pre_ok),
        .rd_ok      (rd_ok),
        .wr_ok      (wr_ok),
        .now        (cyc),
        .cl_rd      (cl_rd),
        .cl_wr      (cl_wr),
        .burst      (burst),
        .wtr        (wtr),
        .act_go     (act_go),
        .pre_go     (pre_go),
        .rd_gate_ok (rd_gate_ok),
        .done_valid (done_valid),
        .done_at    (done_at),
        .proto_err  (proto_err)
    );

    // Latest hidden activate: target minus the direction's delay, not before now
    always_comb begin
        rcd_dir    = bus_wr_mode ? rcd_wr : rcd_rd;
        hide_floor = {1'b0, cyc} + (CW+1)'(rcd_dir);
        if ({1'b0, col_at} >= hide_floor)
            hidden_act_at = col_at - CW'(rcd_dir);
        else
            hidden_act_at = cyc;
    end

endmodule

// File: rtl/bank_timer_chk.sv
module bank_timer_chk #(
    parameter int NB = 4,
    parameter int BW = 2,
    parameter int CW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req,
    input logic [BW-1:0] rd_bank,
    input logic          wr_req,
    input logic [NB-1:0] act_ok,
    input logic [NB-1:0] pre_ok,
    input logic [NB-1:0] rd_ok,
    input logic [NB-1:0] wr_ok,
    input logic          done_valid,
    input logic          proto_err,
    input logic [CW-1:0] now,
    input logic [CW-1:0] hidden_act_at
);

    // R4: a bank cannot be both closed (activate legal) and open (column/precharge legal)
    p_closed_open_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ok & (pre_ok | rd_ok | wr_ok)) == '0);

    // R11: the error flag never clears before reset
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R11: a read strobe while its flag is low raises the error
    p_bad_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ok[rd_bank]) |=> proto_err);

    // R5: a completion report follows a column strobe
    p_done_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(rd_req || wr_req));

    // R10: the hidden activate cycle is never in the past
    p_hidden_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hidden_act_at >= now);

endmodule

bind bank_timer bank_timer_chk #(.NB(NB), .BW(BW), .CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_req        (rd_req),
    .rd_bank       (rd_bank),
    .wr_req        (wr_req),
    .act_ok        (act_ok),
    .pre_ok        (pre_ok),
    .rd_ok         (rd_ok),
    .wr_ok         (wr_ok),
    .done_valid    (done_valid),
    .proto_err     (proto_err),
    .now           (now),
    .hidden_act_at (hidden_act_at)
);

// File: tb/bank_timer_test.sv
`timescale 1ns/1ps
module bank_timer_test;

    localparam int NB = 4;
    localparam int TW = 8;
    localparam int CW = 24;
    localparam int BW = 2;
    localparam int K_ACT = 0;
    localparam int K_PRE = 1;
    localparam int K_RD  = 2;
    localparam int K_WR  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [TW-1:0] cfg_data = '0;
    logic          act_req = 1'b0, pre_req = 1'b0, rd_req = 1'b0, wr_req = 1'b0;
    logic [BW-1:0] act_bank = '0, pre_bank = '0, rd_bank = '0, wr_bank = '0;
    logic          bus_wr_mode = 1'b0;
    logic [CW-1:0] col_at = '0;
    logic [NB-1:0] act_ok, pre_ok, rd_ok, wr_ok;
    logic          done_valid, proto_err;
    logic [CW-1:0] done_at, now, hidden_act_at;
    logic [TW+1:0] access_lat;
    logic [TW:0]   cmd_offset;

    int unsigned cyc;
    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    bank_timer #(.NB(NB), .TW(TW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .act_req(act_req), .act_bank(act_bank), .pre_req(pre_req), .pre_bank(pre_bank),
        .rd_req(rd_req), .rd_bank(rd_bank), .wr_req(wr_req), .wr_bank(wr_bank),
        .bus_wr_mode(bus_wr_mode), .col_at(col_at),
        .act_ok(act_ok), .pre_ok(pre_ok), .rd_ok(rd_ok), .wr_ok(wr_ok),
        .done_valid(done_valid), .done_at(done_at), .now(now),
        .access_lat(access_lat), .cmd_offset(cmd_offset),
        .hidden_act_at(hidden_act_at), .proto_err(proto_err)
    );

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: got %0d expected %0d", req, what, cyc, got, exp);
        end
    endtask

    task automatic next;
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        act_req = 0; pre_req = 0; rd_req = 0; wr_req = 0; cfg_we = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // Drive one strobe for one cycle; c returns its cycle
    task automatic cmd(input int kind, input int bank, output int unsigned c);
        @(negedge clk);
        case (kind)
            K_ACT: begin act_req = 1; act_bank = BW'(bank); end
            K_PRE: begin pre_req = 1; pre_bank = BW'(bank); end
            K_RD:  begin rd_req = 1;  rd_bank = BW'(bank);  end
            default: begin wr_req = 1; wr_bank = BW'(bank); end
        endcase
        #1;
        c = cyc;
        @(negedge clk);
        act_req = 0; pre_req = 0; rd_req = 0; wr_req = 0;
        #1;
    endtask

    task automatic cfg(input int sel, input int val);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 3'(sel); cfg_data = TW'(val);
        @(negedge clk);
        cfg_we = 0;
        #1;
    endtask

    task automatic t_reset;
        do_reset();
        chk("R1", "act_ok", act_ok, 4'hF);
        chk("R1", "pre_ok", pre_ok, 0);
        chk("R1", "rd_ok", rd_ok, 0);
        chk("R1", "wr_ok", wr_ok, 0);
        chk("R1", "proto_err", proto_err, 0);
        chk("R1", "done_valid", done_valid, 0);
        chk("R1", "now at start", now, 0);
        repeat (3) next();
        chk("R1", "now counting", now, cyc);
        chk("R8", "access_lat default", access_lat, 12);
        chk("R9", "cmd_offset default", cmd_offset, 7);
    endtask

    // Default timings: write delays follow read delays
    task automatic t_default_timing;
        int unsigned a, w, p;
        cmd(K_ACT, 1, a);
        for (int i = 0; i < 10; i++) begin
            chk("R2", "rd_ok[1] after act", rd_ok[1], (cyc >= a + 4) ? 1 : 0);
            chk("R3", "wr_ok[1] default delay", wr_ok[1], (cyc >= a + 4) ? 1 : 0);
            chk("R4", "pre_ok[1] after act", pre_ok[1], (cyc >= a + 8) ? 1 : 0);
            chk("R4", "act_ok[1] while open", act_ok[1], 0);
            next();
        end
        cmd(K_WR, 1, w);
        chk("R6", "done_valid after write", done_valid, 1);
        chk("R6", "done_at default write lat", done_at, w + 5 + 2);
        for (int i = 0; i < 11; i++) begin
            chk("R7", "rd_ok[1] write-to-read", rd_ok[1], (cyc >= w + 9) ? 1 : 0);
            next();
        end
        chk("R5", "done_valid drops", done_valid, 0);
        cmd(K_PRE, 1, p);
        for (int i = 0; i < 5; i++) begin
            chk("R4", "act_ok[1] after pre", act_ok[1], (cyc >= p + 3) ? 1 : 0);
            chk("R4", "rd_ok[1] closed", rd_ok[1], 0);
            next();
        end
        chk("R11", "no error on legal traffic", proto_err, 0);
    endtask

    // Distinct write timings, config gating
    task automatic t_program;
        int unsigned a, w, r, p;
        cfg(1, 6);
        cfg(3, 7);
        chk("R9", "cmd_offset with rcd_wr 6", cmd_offset, 9);
        chk("R8", "access_lat unchanged", access_lat, 12);
        cmd(K_ACT, 2, a);
        for (int i = 0; i < 8; i++) begin
            chk("R3", "wr_ok[2] write delay", wr_ok[2], (cyc >= a + 6) ? 1 : 0);
            chk("R2", "rd_ok[2] read delay", rd_ok[2], (cyc >= a + 4) ? 1 : 0);
            next();
        end
        cfg(0, 10);
        chk("R12", "access_lat after blocked write", access_lat, 12);
        chk("R12", "cmd_offset after blocked write", cmd_offset, 9);
        cmd(K_WR, 2, w);
        chk("R6", "done_at programmed write lat", done_at, w + 7 + 2);
        for (int i = 0; i < 12; i++) begin
            chk("R7", "rd_ok[2] uses write latency", rd_ok[2], (cyc >= w + 11) ? 1 : 0);
            next();
        end
        cmd(K_RD, 2, r);
        chk("R5", "done_valid after read", done_valid, 1);
        chk("R5", "done_at read", done_at, r + 5 + 2);
        cmd(K_PRE, 2, p);
        repeat (3) next();
        cfg(0, 10);
        chk("R12", "access_lat after accepted write", access_lat, 18);
        chk("R9", "cmd_offset read delay larger", cmd_offset, 13);
        chk("R11", "no error so far", proto_err, 0);
    endtask

    // rcd_rd = 10, rcd_wr = 6 at this point
    task automatic t_hidden;
        @(negedge clk);
        bus_wr_mode = 0; col_at = CW'(cyc + 30);
        #1;
        chk("R10", "hidden read far", hidden_act_at, cyc + 20);
        bus_wr_mode = 1;
        #1;
        chk("R10", "hidden write far", hidden_act_at, cyc + 24);
        bus_wr_mode = 0; col_at = CW'(cyc + 5);
        #1;
        chk("R10", "hidden read clamp", hidden_act_at, cyc);
        bus_wr_mode = 1; col_at = CW'(cyc + 6);
        #1;
        chk("R10", "hidden write edge", hidden_act_at, cyc);
        bus_wr_mode = 1; col_at = CW'(cyc + 7);
        #1;
        chk("R10", "hidden write edge+1", hidden_act_at, cyc + 1);
    endtask

    task automatic t_violation;
        int unsigned c, a;
        do_reset();
        cmd(K_RD, 3, c);
        chk("R11", "error after read to closed bank", proto_err, 1);
        chk("R11", "bank 3 still closed", act_ok[3], 1);
        repeat (4) next();
        chk("R11", "error sticky", proto_err, 1);
        do_reset();
        @(negedge clk);
        act_req = 1; act_bank = 0; pre_req = 1; pre_bank = 1;
        @(negedge clk);
        act_req = 0; pre_req = 0;
        #1;
        chk("R11", "error after two strobes", proto_err, 1);
        repeat (5) next();
        chk("R11", "bank 0 not opened", act_ok[0], 1);
        chk("R11", "bank 0 no read", rd_ok[0], 0);
        do_reset();
        cmd(K_ACT, 0, a);
        cmd(K_ACT, 0, c);
        chk("R11", "error after activate on open bank", proto_err, 1);
        for (int i = 0; i < 8; i++) begin
            chk("R11", "pre_ok[0] keeps first activate", pre_ok[0], (cyc >= a + 8) ? 1 : 0);
            next();
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_default_timing();
        t_program();
        t_hidden();
        t_violation();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule